// File: doc/BRIEF.md
# Threshold-Alert Transmit FIFO

This block is the transmit-side buffer of a serial port. A processor pushes samples into it and the serializer pops them. A sample is one byte in narrow mode and two bytes in wide mode, chosen by the `wide_mode` input. The fill level is tracked in bytes. A registered `alert` output tells the processor that the buffer needs more data once the byte count has dropped to a programmable threshold.

A small register port exposes two locations. Address 0 holds the 5-bit byte threshold. Address 1 is a read-only status byte with transmitter-empty, transmitter-ready and full flags in the positions a shared status decoder expects. The receive-side flag positions read as zero. A change of sample size empties the buffer, so that no half-sample is ever left stored.

Top module: `txq_alert_fifo`

## Requirements
- R1: Register address 0 holds a 5-bit threshold that resets to 0. `reg_rdata[4:0]` returns the value last written to `reg_wdata[4:0]` while `reg_we` was high. Bits 7:5 always read 0, and writes to them have no effect.
- R2: Register address 1 is a registered status byte that is all zeros during reset. Bit 3 is transmitter-empty, bit 2 is transmitter-ready and bit 1 is full. Bits 7:4 and bit 0 are 0. The byte shows the state of the previous clock.
- R3: `alert` is 0 during reset. On every clock it registers whether the byte count is less than or equal to the threshold, so it follows the count or the threshold one clock late.
- R4: With `wide_mode`=0, an accepted write stores `wr_data[7:0]` and adds 1 to the byte count. With `wide_mode`=1, it stores `wr_data[7:0]` first and then `wr_data[15:8]`, and adds 2.
- R5: Bytes leave in write order. One clock after an accepted pop, `rd_valid` pulses high and `rd_data` holds the sample. In wide mode the sample is {second byte, first byte}; in narrow mode it is {8'h00, byte}. The byte count drops by the sample size.
- R6: The capacity is 32 bytes. A write is refused when free space is smaller than one sample. A refused write leaves the count and the stored bytes unchanged.
- R7: Transmitter-ready is 1 exactly when free space is at least one sample. Full is 1 exactly when it is not.
- R8: Transmitter-empty is 1 only when the byte count is 0 and no sample was handed out (`rd_valid`) in the same clock.
- R9: A pop requested while fewer bytes than one sample remain is ignored. `rd_valid` stays 0 and `rd_data` keeps its last value.
- R10: In a clock where `wide_mode` differs from its value in the previous clock, the FIFO is flushed to zero bytes. A write or pop requested in that clock is ignored.
- R11: A write and a pop in the same clock are both accepted when each one is allowed on its own. The count then changes by the difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 0: one-byte samples, 1: two-byte samples |
| wr_en | input | 1 | Push one sample |
| wr_data | input | 16 | Sample to push (low byte first) |
| rd_en | input | 1 | Pop one sample |
| rd_data | output | 16 | Last popped sample |
| rd_valid | output | 1 | Pulse: rd_data updated by a pop |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0: threshold, 1: status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| alert | output | 1 | Byte count at or below threshold |

## Verification
The hardest state to reach is the edge between a count of 31 and 32 bytes with the threshold at 31. Here the alert, the ready flag and the full flag all flip on a single byte. The stimulus fills the buffer one byte at a time and then sends a write that must be refused. It then drains the buffer, checking every byte in order. The one-clock window in which transmitter-empty stays low while the last byte is handed out is caught by reading status on each of the two clocks after the final pop. A vector table covers the mode-change flush, the combined write and pop, and a pop from an empty buffer.

// File: rtl/txq_pkg.sv
package txq_pkg;

   localparam int unsigned REG_W = 8;

   typedef enum logic {
      TXQ_A_THR  = 1'b0,
      TXQ_A_STAT = 1'b1
   } txq_addr_e;

   // bit order is fixed by the shared status decoder (bit 7 down to bit 0)
   typedef struct packed {
      logic rx_brk;
      logic rx_frm;
      logic rx_par;
      logic rx_ovr;
      logic tx_emp;
      logic tx_rdy;
      logic full;
      logic rx_rdy;
   } txq_stat_t;

endpackage

// File: rtl/txq_level.sv
module txq_level #(
   parameter int unsigned DEPTH = 32,
   parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             wide,
   input  logic             wr_req,
   input  logic             rd_req,
   output logic             wr_ok,
   output logic             rd_ok,
   output logic [CNT_W-1:0] cnt,
   output logic             room
);

   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

   logic [CNT_W-1:0] cnt_q, cnt_n, samp, free;

   assign samp  = wide ? CNT_W'(2) : CNT_W'(1);
   assign free  = DEPTH_C - cnt_q;
   assign room  = (free >= samp);
   assign wr_ok = wr_req && !flush && room;
   assign rd_ok = rd_req && !flush && (cnt_q >= samp);

   always_comb begin
      cnt_n = cnt_q;
      if (wr_ok) cnt_n = cnt_n + samp;
      if (rd_ok) cnt_n = cnt_n - samp;
      if (flush) cnt_n = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_n;
   end

   assign cnt = cnt_q;

   // R6
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= DEPTH_C);

   // R6
   refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !room && !rd_req && !flush) |=> $stable(cnt_q));

   // R10
   flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (cnt_q == '0));

endmodule

// File: rtl/txq_store.sv
module txq_store #(
   parameter int unsigned DEPTH  = 32,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned PTR_W  = $clog2(DEPTH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                flush,
   input  logic                wide,
   input  logic                wr_ok,
   input  logic                rd_ok,
   input  logic [2*BYTE_W-1:0] wr_data,
   output logic [2*BYTE_W-1:0] rd_data,
   output logic                rd_valid
);

   logic [PTR_W-1:0]  wp_q, rp_q, wp_hi, rp_hi, step;
   logic [BYTE_W-1:0] cells [DEPTH];

   assign step  = wide ? PTR_W'(2) : PTR_W'(1);
   assign wp_hi = wp_q + PTR_W'(1);
   assign rp_hi = rp_q + PTR_W'(1);

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      localparam logic [PTR_W-1:0] IDX = PTR_W'(i);
      logic [BYTE_W-1:0] cell_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                                cell_q <= '0;
         else if (wr_ok && wp_q == IDX)             cell_q <= wr_data[BYTE_W-1:0];
         else if (wr_ok && wide && wp_hi == IDX)    cell_q <= wr_data[2*BYTE_W-1:BYTE_W];
      end
      assign cells[i] = cell_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q     <= '0;
         rp_q     <= '0;
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else if (flush) begin
         wp_q     <= '0;
         rp_q     <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_ok;
         if (wr_ok) wp_q <= wp_q + step;
         if (rd_ok) begin
            rp_q    <= rp_q + step;
            rd_data <= {wide ? cells[rp_hi] : {BYTE_W{1'b0}}, cells[rp_q]};
         end
      end
   end

   // R5
   narrow_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ok && !wide) |=> (rd_data[2*BYTE_W-1:BYTE_W] == '0));

endmodule

// File: rtl/txq_csr.sv
module txq_csr
   import txq_pkg::*;
#(
   parameter int unsigned THR_W = 5,
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic             reg_addr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic [CNT_W-1:0] cnt,
   input  logic             room,
   input  logic             handoff,
   output logic             alert
);

   logic [THR_W-1:0] thr_q;
   txq_stat_t        stat_q, stat_n;
   logic             alert_q;

   always_comb begin
      stat_n        = '0;
      stat_n.tx_emp = (cnt == '0) && !handoff;
      stat_n.tx_rdy = room;
      stat_n.full   = !room;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         thr_q   <= '0;
         stat_q  <= '0;
         alert_q <= 1'b0;
      end else begin
         if (reg_we && txq_addr_e'(reg_addr) == TXQ_A_THR) thr_q <= reg_wdata[THR_W-1:0];
         stat_q  <= stat_n;
         alert_q <= (cnt <= CNT_W'(thr_q));
      end
   end

   assign reg_rdata = (txq_addr_e'(reg_addr) == TXQ_A_THR) ? REG_W'(thr_q) : stat_q;
   assign alert     = alert_q;

   // R1
   thr_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_addr |-> ((reg_rdata >> THR_W) == '0));

   // R8
   handoff_emp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      handoff |=> !stat_q.tx_emp);

   // R2
   rx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(stat_q.rx_brk || stat_q.rx_frm || stat_q.rx_par || stat_q.rx_ovr || stat_q.rx_rdy));

endmodule

// File: rtl/txq_alert_fifo.sv
module txq_alert_fifo
   import txq_pkg::*;
#(
   parameter int unsigned DEPTH  = 32,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned THR_W  = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wide_mode,
   input  logic                wr_en,
   input  logic [2*BYTE_W-1:0] wr_data,
   input  logic                rd_en,
   output logic [2*BYTE_W-1:0] rd_data,
   output logic                rd_valid,
   input  logic                reg_we,
   input  logic                reg_addr,
   input  logic [REG_W-1:0]    reg_wdata,
   output logic [REG_W-1:0]    reg_rdata,
   output logic                alert
);

   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam int unsigned PTR_W = $clog2(DEPTH);

   initial begin : param_chk
      assert ((1 << PTR_W) == DEPTH && DEPTH >= 2)
         else $error("DEPTH must be a power of two");
      assert (THR_W >= 1 && THR_W <= REG_W && (1 << THR_W) <= DEPTH + 1)
         else $error("THR_W out of range");
   end

   logic             mode_q, flush, wr_ok, rd_ok, room;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= 1'b0;
      else        mode_q <= wide_mode;
   end

   assign flush = (wide_mode != mode_q);

   txq_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) level_i (
      .clk, .rst_n, .flush, .wide(wide_mode),
      .wr_req(wr_en), .rd_req(rd_en),
      .wr_ok, .rd_ok, .cnt, .room
   );

   txq_store #(.DEPTH(DEPTH), .BYTE_W(BYTE_W), .PTR_W(PTR_W)) store_i (
      .clk, .rst_n, .flush, .wide(wide_mode),
      .wr_ok, .rd_ok, .wr_data, .rd_data, .rd_valid
   );

   txq_csr #(.THR_W(THR_W), .CNT_W(CNT_W)) csr_i (
      .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
      .cnt, .room, .handoff(rd_valid), .alert
   );

   // R9
   short_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !flush && (cnt < (wide_mode ? CNT_W'(2) : CNT_W'(1))))
         |=> (!rd_valid && $stable(rd_data)));

   // R4
   wide_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && !flush) |-> !cnt[0]);

endmodule

// File: tb/txq_alert_fifo_tb_top.sv
module txq_alert_fifo_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wide_mode = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        rd_valid;
   logic        reg_we = 1'b0, reg_addr = 1'b0;
   logic [7:0]  reg_wdata = '0, reg_rdata;
   logic        alert;

   int checks = 0, fails = 0;
   logic [15:0] last;

   always #4ns clk = ~clk;

   txq_alert_fifo dut_i (.*);

   typedef struct packed {
      logic        wide;
      logic        wr;
      logic        rd;
      logic [15:0] wd;
      logic        vld;
      logic [15:0] rdat;
      logic [5:0]  cnt;
   } vec_t;

   // threshold 2 for the whole table
   localparam vec_t VECS [12] = '{
      '{1'b0, 1'b1, 1'b0, 16'h00A1, 1'b0, 16'h0000, 6'd1},
      '{1'b0, 1'b1, 1'b0, 16'h00B2, 1'b0, 16'h0000, 6'd2},
      '{1'b0, 1'b1, 1'b0, 16'h00C3, 1'b0, 16'h0000, 6'd3},
      '{1'b0, 1'b0, 1'b1, 16'h0000, 1'b1, 16'h00A1, 6'd2},
      '{1'b0, 1'b1, 1'b1, 16'h00D4, 1'b1, 16'h00B2, 6'd2},
      '{1'b1, 1'b1, 1'b0, 16'h5566, 1'b0, 16'h00B2, 6'd0},
      '{1'b1, 1'b1, 1'b0, 16'h5566, 1'b0, 16'h00B2, 6'd2},
      '{1'b1, 1'b1, 1'b0, 16'h7788, 1'b0, 16'h00B2, 6'd4},
      '{1'b1, 1'b0, 1'b1, 16'h0000, 1'b1, 16'h5566, 6'd2},
      '{1'b1, 1'b0, 1'b1, 16'h0000, 1'b1, 16'h7788, 6'd0},
      '{1'b1, 1'b0, 1'b1, 16'h0000, 1'b0, 16'h7788, 6'd0},
      '{1'b0, 1'b1, 1'b0, 16'h0011, 1'b0, 16'h7788, 6'd0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [7:0] stat_of(input logic [5:0] c, input logic w);
      int sb = w ? 2 : 1;
      int fr = 32 - int'(c);
      return {4'b0000, c == 0, fr >= sb, fr < sb, 1'b0};
   endfunction

   task automatic rd_reg(input logic a, output logic [7:0] v);
      reg_addr = a;
      #1ns;
      v = reg_rdata;
   endtask

   task automatic wr_thr(input logic [7:0] v);
      reg_we = 1'b1; reg_addr = 1'b0; reg_wdata = v;
      cyc();
      reg_we = 1'b0;
   endtask

   task automatic push(input logic [15:0] d);
      wr_en = 1'b1; wr_data = d;
      cyc();
      wr_en = 1'b0;
   endtask

   task automatic settle_chk(input string req, input logic [5:0] c, input logic [4:0] t);
      logic [7:0] v;
      cyc(); cyc();
      rd_reg(1'b1, v);
      chk({req, " status"}, v, stat_of(c, wide_mode));
      chk({req, " alert"}, alert, c <= t);
   endtask

   initial begin : watchdog
      #(8ns * 200000);
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      logic [7:0] v;
      // reset state: R2 R1 R3
      repeat (3) @(negedge clk);
      rd_reg(1'b1, v); chk("R2 reset status", v, 8'h00);
      rd_reg(1'b0, v); chk("R1 reset thr", v, 8'h00);
      chk("R3 reset alert", alert, 1'b0);
      chk("R5 reset valid", rd_valid, 1'b0);
      rst_n = 1'b1;
      cyc();

      // R1 reserved bits
      wr_thr(8'hFF); rd_reg(1'b0, v); chk("R1 rsvd", v, 8'h1F);
      wr_thr(8'hE2); rd_reg(1'b0, v); chk("R1 value", v, 8'h02);

      // table walk: R4 R5 R9 R10 R11 R7 R3
      foreach (VECS[i]) begin
         wide_mode = VECS[i].wide; wr_en = VECS[i].wr; rd_en = VECS[i].rd;
         wr_data = VECS[i].wd;
         cyc();
         wr_en = 1'b0; rd_en = 1'b0;
         chk($sformatf("R5/R9/R10/R11 vec%0d valid", i), rd_valid, VECS[i].vld);
         chk($sformatf("R5/R4/R9 vec%0d data", i), rd_data, VECS[i].rdat);
         settle_chk($sformatf("R7/R3/R10 vec%0d", i), VECS[i].cnt, 5'd2);
      end

      // boundary at 31/32 bytes, narrow mode: R6 R7 R3
      wr_thr(8'h1F);
      for (int i = 0; i < 31; i++) push(16'(i));
      settle_chk("R3 31 bytes", 6'd31, 5'd31);
      push(16'd31);
      settle_chk("R7 full 32 bytes", 6'd32, 5'd31);
      push(16'h00EE);
      settle_chk("R6 refused", 6'd32, 5'd31);
      for (int i = 0; i < 32; i++) begin
         rd_en = 1'b1; cyc(); rd_en = 1'b0;
         chk("R5 order", rd_data, 16'(i));
      end
      // R8: empty flag held low during the handoff clock
      cyc(); rd_reg(1'b1, v); chk("R8 handoff", v[3], 1'b0);
      cyc(); rd_reg(1'b1, v); chk("R8 empty", v[3], 1'b1);
      rd_en = 1'b1; cyc(); rd_en = 1'b0;
      chk("R9 empty pop valid", rd_valid, 1'b0);
      chk("R9 empty pop data", rd_data, 16'h001F);

      // wide mode full: R6 R4
      wide_mode = 1'b1; cyc();
      for (int i = 0; i < 16; i++) push({8'(i), 8'(~i)});
      settle_chk("R6 wide full", 6'd32, 5'd31);
      push(16'hABCD);
      settle_chk("R6 wide refused", 6'd32, 5'd31);
      rd_en = 1'b1; cyc(); rd_en = 1'b0;
      chk("R4 wide first", rd_data, 16'h00FF);
      last = rd_data;
      settle_chk("R4 wide count", 6'd30, 5'd31);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule